// File: doc/BRIEF.md
# Slider-Defined Step and Slope LFO

This block produces a low-frequency control waveform from a small set of point levels, typically set by a row of sliders, with eight or fourteen points being common choices. A fractional phase register advances by a programmable rate increment on each sample strobe. Every time that fraction overflows, a separate point index steps to the next point. After the last point the index returns to point 0, so one full waveform cycle spans all points.

Two output modes are available. In levels mode the current point's value is held flat for its whole segment. This gives steps, pulses and short sequences. In slopes mode the output ramps linearly from the current point toward the next one, weighted by the top bits of the fraction. The final segment ramps back toward point 0.

The point values and the mode select are captured only on a strobe. A slider that moves between samples therefore cannot disturb the output mid-sample.

Top module: `graph_lfo`

## Requirements
- R1: A synchronous reset clears the fraction, the point index, the captured point values and the captured mode, so `sample` reads 0 on the cycle after reset.
- R2: On each cycle with `tick` high, the fraction becomes (fraction + `rate`) mod 2^FW. A `rate` of 0 leaves the phase frozen.
- R3: A carry out of the fraction moves the point index up by one. From point NPTS-1 it wraps to point 0, including for counts that are not a power of two, such as 14.
- R4: With the captured mode at 0 (levels), `sample` equals the captured value of the current point k. Point k is taken from bits [k*VW +: VW] of `levels`.
- R5: With the captured mode at 1 (slopes), `sample` equals a + floor((b - a) * w / 2^WW). Here a is the current point, b is the next point (wrapping), and w is the top WW bits of the fraction.
- R6: In slopes mode, `sample` always lies between a and b inclusive. On the last point, b is point 0.
- R7: On a cycle with `tick` low, the phase, the index and `sample` keep their values.
- R8: Changes on `levels` and `slopes` between strobes have no effect on `sample` until the next strobe captures them.
- R9: Even at the largest `rate` (2^FW - 1), the index advances by at most one point per strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Sample strobe; advances phase and captures inputs |
| slopes | input | 1 | Mode select: 0 levels, 1 slopes |
| rate | input | FW | Phase increment per strobe |
| levels | input | NPTS*VW | Point values, point k at bits [k*VW +: VW] |
| sample | output | VW | Output sample word |

## Verification
The hardest situation to reach is slopes mode on the last point of a non-power-of-two count. There the index must wrap to 0 while the ramp heads back toward point 0, and a fraction carry can land on the same strobe as a change of captured values. The bench builds a 14-point instance and drives large rates, close to a quarter of a point per strobe and up to the full-scale rate. This makes the index pass the wrap many times within a few hundred cycles. The slider values and the mode are changed between strobes, so that the capture at the wrap edge is exercised.

// File: rtl/graph_lfo.sv
module graph_lfo #(
  parameter int NPTS = 8,
  parameter int VW   = 12,
  parameter int FW   = 24,
  parameter int WW   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 slopes,
  input  logic [FW-1:0]        rate,
  input  logic [NPTS*VW-1:0]   levels,
  output logic [VW-1:0]        sample
);
  localparam int IW = (NPTS > 1) ? $clog2(NPTS) : 1;
  localparam int PW = VW + WW + 2;
  localparam logic [IW-1:0] LAST = IW'(NPTS - 1);

  logic [FW-1:0]      frac;
  logic [IW-1:0]      idx;
  logic [NPTS*VW-1:0] held;
  logic               mode_q;

  logic [FW:0]        sum;
  logic [IW-1:0]      idx_nx;
  logic [VW-1:0]      a, b;
  logic [WW-1:0]      w;
  logic signed [VW:0] diff;
  logic signed [PW-1:0] prod, mix;

  assign sum    = {1'b0, frac} + {1'b0, rate};
  assign idx_nx = (idx == LAST) ? '0 : idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      frac   <= '0;
      idx    <= '0;
      held   <= '0;
      mode_q <= 1'b0;
    end else if (tick) begin
      frac   <= sum[FW-1:0];
      if (sum[FW]) idx <= idx_nx;
      held   <= levels;
      mode_q <= slopes;
    end
  end

  assign a    = held[idx*VW +: VW];
  assign b    = held[idx_nx*VW +: VW];
  assign w    = frac[FW-1 -: WW];
  assign diff = $signed({1'b0, b}) - $signed({1'b0, a});
  assign prod = diff * $signed({1'b0, w});
  assign mix  = $signed({{(WW+2){1'b0}}, a}) + (prod >>> WW);

  assign sample = mode_q ? mix[VW-1:0] : a;
endmodule

module graph_lfo_props #(
  parameter int NPTS = 8,
  parameter int VW   = 12,
  parameter int FW   = 24,
  parameter int WW   = 8,
  parameter int IW   = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     tick,
  input logic [FW-1:0]            frac,
  input logic [IW-1:0]            idx,
  input logic                     mode_q,
  input logic [VW-1:0]            a,
  input logic [VW-1:0]            b,
  input logic [VW-1:0]            sample,
  input logic signed [VW+WW+1:0]  mix
);
  localparam logic [IW-1:0] LAST = IW'(NPTS - 1);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (frac == '0 && idx == '0 && sample == '0));

  assert_idx_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    idx <= LAST);

  assert_hold_without_tick_R7: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(frac) && $stable(idx) && $stable(sample)));

  assert_single_step_R9: assert property (@(posedge clk) disable iff (rst)
    tick |=> (idx == $past(idx) ||
              idx == (($past(idx) == LAST) ? '0 : $past(idx) + 1'b1)));

  assert_between_points_R6: assert property (@(posedge clk) disable iff (rst)
    mode_q |-> (mix[VW+WW+1:VW] == '0 &&
                ((a <= b) ? (sample >= a && sample <= b)
                          : (sample <= a && sample >= b))));
endmodule

bind graph_lfo graph_lfo_props #(
  .NPTS(NPTS), .VW(VW), .FW(FW), .WW(WW), .IW(IW)
) props (
  .clk(clk), .rst(rst), .tick(tick), .frac(frac), .idx(idx),
  .mode_q(mode_q), .a(a), .b(b), .sample(sample), .mix(mix)
);

// File: tb/graph_lfo_test.sv
module graph_lfo_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 14;
  localparam int VW = 12;
  localparam int FW = 24;
  localparam int WW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic slopes = 1'b0;
  logic [FW-1:0] rate = '0;
  logic [N*VW-1:0] levels = '0;
  logic [VW-1:0] sample;

  int drv_pts [N];
  int m_pts [N];
  int m_frac, m_idx, m_mode;
  int compared = 0, mismatched = 0, cycles = 0;
  string cur_req = "R1";

  graph_lfo #(.NPTS(N), .VW(VW), .FW(FW), .WW(WW)) uut (
    .clk(clk), .rst(rst), .tick(tick), .slopes(slopes),
    .rate(rate), .levels(levels), .sample(sample));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog expired got %0d cycles exp fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  function automatic int expected();
    int a, b, w, t;
    a = m_pts[m_idx];
    b = m_pts[(m_idx + 1) % N];
    if (m_mode == 0) return a;
    w = m_frac >> (FW - WW);
    t = (b - a) * w;
    return a + (t >>> WW);
  endfunction

  task automatic step();
    longint s;
    for (int k = 0; k < N; k++) levels[k*VW +: VW] = drv_pts[k][VW-1:0];
    @(posedge clk);
    if (rst) begin
      m_frac = 0; m_idx = 0; m_mode = 0;
      for (int k = 0; k < N; k++) m_pts[k] = 0;
    end else if (tick) begin
      s = longint'(m_frac) + longint'(rate);
      if (s >= (longint'(1) << FW)) begin
        s = s - (longint'(1) << FW);
        m_idx = (m_idx + 1) % N;
      end
      m_frac = int'(s);
      for (int k = 0; k < N; k++) m_pts[k] = drv_pts[k];
      m_mode = slopes ? 1 : 0;
    end
    @(negedge clk);
    compared++;
    if (int'(sample) != expected()) begin
      mismatched++;
      $display("FAIL %s got %0d exp %0d (idx %0d)", cur_req, sample, expected(), m_idx);
    end
  endtask

  task automatic run(input int n, input int tick_pct);
    for (int i = 0; i < n; i++) begin
      tick = ($urandom_range(99) < tick_pct);
      step();
    end
  endtask

  initial begin
    m_frac = 0; m_idx = 0; m_mode = 0;
    for (int k = 0; k < N; k++) begin
      drv_pts[k] = (k * 293 + 40) % 4096;
      m_pts[k] = 0;
    end
    @(negedge clk);
    cur_req = "R1"; rst = 1'b1; run(3, 100);
    rst = 1'b0;

    cur_req = "R4"; slopes = 1'b0; rate = 24'h400000; run(80, 100);
    cur_req = "R3"; rate = 24'h3FFFF1; run(120, 80);

    cur_req = "R5"; slopes = 1'b1; rate = 24'h012345; run(600, 70);
    cur_req = "R6"; rate = 24'h40F0F0;
    drv_pts[N-1] = 4095; drv_pts[0] = 0; run(200, 90);
    drv_pts[N-1] = 3; drv_pts[0] = 4000; run(200, 90);

    cur_req = "R7"; tick = 1'b0;
    for (int i = 0; i < 20; i++) step();

    cur_req = "R8";
    for (int i = 0; i < 20; i++) begin
      tick = 1'b0;
      drv_pts[$urandom_range(N-1)] = int'($urandom_range(4095));
      slopes = ~slopes;
      step();
    end
    tick = 1'b1; step();

    cur_req = "R9"; rate = 24'hFFFFFF; run(60, 100);
    cur_req = "R2"; rate = 24'h000000; run(30, 100);
    rate = 24'h0000FF; run(40, 100);

    cur_req = "R1"; rst = 1'b1; run(2, 100); rst = 1'b0;
    slopes = 1'b0; run(5, 0);

    cur_req = "R5";
    for (int i = 0; i < 40; i++) begin
      rate = FW'($urandom_range(24'hFFFFFF));
      slopes = $urandom_range(1);
      for (int k = 0; k < N; k++) drv_pts[k] = int'($urandom_range(4095));
      run(50, 60);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule